// File: doc/BRIEF.md
# Receive Phase Alignment Sequencer

This block drives the automatic phase and delay alignment handshake of a serial receiver that runs with its elastic buffer bypassed. After reset, after a receiver reset completes or after a receive rate change, it waits until the line has left electrical idle and clock-data recovery reports lock. It then issues a short delay-reset start pulse and follows the status returned by the transceiver's alignment circuitry: first delay-reset-done, then sync-done. When sync-done is seen, phase-align-done decides whether the alignment succeeded.

Once alignment is complete, the sequencer leaves the delay alignment running so that it can track temperature and voltage drift, and it does not restart on its own. It raises its aligned flag only while sync-done, phase-align-done and the fabric's data-valid indication are all high. If the fabric reports invalid data while lock is held, the phase alignment is incomplete, a handshake wait runs too long, or phase-align-done is low at completion, the whole procedure is repeated and a saturating retry counter is incremented. A loss of lock or a return to electrical idle sends the sequencer back to waiting for its start conditions without counting a retry.

Top module: `rx_phase_align_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `dlyrst_pulse` low, `aligned` low and `retry_count` zero, whatever the other inputs are.
- R2: `dlyrst_pulse` rises only in the cycle after a clock edge at which `elec_idle` was low and `cdr_lock` was high. When the sequencer is waiting and both conditions hold at an edge (including the first edge after reset release), the pulse is high in the very next cycle.
- R3: An uninterrupted start pulse lasts exactly `PULSE_CYCLES` consecutive cycles. The parameter must lie between 1 and 4, so that the pulse stays under 50 ns at a 100 MHz control clock.
- R4: After the pulse, the sequencer waits for `dlyrst_done` high and then for `sync_done` high. If `phalign_done` is high at the edge where `sync_done` is seen, and `data_valid` is high, `aligned` is high from the following cycle on.
- R5: If `phalign_done` is low at the edge where `sync_done` is seen, `aligned` stays low, `retry_count` rises by one, and a new pulse starts two cycles after the completion cycle.
- R6: `aligned` is high only while `sync_done`, `phalign_done` and `data_valid` are all high in the completed state. In that state, lowering `sync_done` or `phalign_done` with `data_valid` high clears `aligned` in the same cycle without a restart.
- R7: In the completed state with the link intact, `data_valid` low clears `aligned` in the same cycle, adds one to `retry_count` at the next edge, and a new pulse is high two cycles after the invalid-data cycle.
- R8: `cdr_lock` low or `elec_idle` high forces `dlyrst_pulse` and `aligned` low in that same cycle and returns the sequencer to its waiting state without changing `retry_count`. No pulse is issued until both conditions return, and the next pulse is a fresh full-length pulse.
- R9: A high `restart_evt` with the link intact returns the sequencer to waiting without changing `retry_count`, and a new pulse is high two cycles later. It wins over an invalid-data retry in the same cycle.
- R10: Remaining `TIMEOUT_CYCLES` cycles in the delay-reset-done wait or in the sync-done wait without the awaited status counts as a retry: `retry_count` rises by one, and a new pulse follows one waiting cycle later. A link loss in the expiring cycle wins, and no retry is counted.
- R11: `retry_count` changes by exactly +1 per retry and saturates at 2^`RETRY_W`-1.
- R12: Once `aligned` is high, no start pulse is issued in the next cycle. While the link and all status inputs hold, the sequencer stays complete indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_evt | input | 1 | Receiver reset completed or receive rate changed; requests a new alignment |
| elec_idle | input | 1 | Receiver sees electrical idle on the line |
| cdr_lock | input | 1 | Clock-data recovery is locked |
| dlyrst_done | input | 1 | Delay-reset completion status from the transceiver |
| sync_done | input | 1 | Alignment procedure completion status |
| phalign_done | input | 1 | Phase alignment achieved and held |
| data_valid | input | 1 | Fabric judges the received data valid |
| dlyrst_pulse | output | 1 | Delay-reset start pulse to the transceiver |
| aligned | output | 1 | Receiver aligned and fabric data valid |
| retry_count | output | RETRY_W | Saturating count of alignment retries |

## Verification
Several functions can fall in the same cycle. A wait timeout can expire in the cycle where lock is lost, and a restart request can coincide with invalid fabric data in the completed state. A start pulse can also be cut short by a return to electrical idle. The bench brings each of these about by counting cycles from the end of a pulse and changing the second input exactly in the expiring or completed cycle. It then judges the priority from the retry count, which must not move, and from the time to the next pulse, which must be a fresh pulse of full length. The timeout windows are swept for both wait states over enough retries to reach saturation, with the expected gap and count computed from the parameters.

// File: rtl/rpa_pkg.sv
// Package rpa_pkg
// Shared state encoding for the receive phase alignment sequencer.
// Assumes a single control clock domain for all users.
package rpa_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_COND = 3'd0,  // waiting for idle exit and lock
        ST_START     = 3'd1,  // driving the delay-reset start pulse
        ST_WAIT_DRD  = 3'd2,  // waiting for delay-reset-done
        ST_WAIT_SYNC = 3'd3,  // waiting for sync-done
        ST_LOCKED    = 3'd4   // alignment complete, tracking left running
    } rpa_state_e;

endpackage

// File: rtl/rpa_dwell_timer.sv
// Module rpa_dwell_timer
// Counts the cycles spent in the current sequencer state. It restarts
// from zero on the edge where the state changes and saturates at its
// maximum value. Assumes the caller sizes CNT_W to cover every compare value.
module rpa_dwell_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] dwell
);

    localparam logic [CNT_W-1:0] DWELL_TOP = {CNT_W{1'b1}};

    // Purpose: restart on a state change, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell <= '0;
        end else if (clear) begin
            dwell <= '0;
        end else if (dwell != DWELL_TOP) begin
            dwell <= dwell + 1'b1;
        end
    end

endmodule

// File: rtl/rpa_sat_counter.sv
// Module rpa_sat_counter
// Saturating up-counter for alignment retries. Each cycle with bump high
// adds one until all bits are set. Assumes one bump per retry event.
module rpa_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] COUNT_TOP = {W{1'b1}};

    // Purpose: increment on each retry, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump && (count != COUNT_TOP)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/rpa_fsm.sv
// Module rpa_fsm
// State machine of the alignment handshake. A link loss (idle or no lock)
// comes first, then a restart request, then the per-state handshake.
// A retry is flagged on a wait timeout, a failed phase result, or invalid
// fabric data after completion. Assumes dwell counts cycles in the state.
module rpa_fsm
    import rpa_pkg::*;
#(
    parameter int PULSE_CYCLES   = 3,
    parameter int TIMEOUT_CYCLES = 1024,
    parameter int CNT_W          = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_ok,
    input  logic             restart_evt,
    input  logic             dlyrst_done,
    input  logic             sync_done,
    input  logic             phalign_done,
    input  logic             data_valid,
    input  logic [CNT_W-1:0] dwell,
    output rpa_state_e       state,
    output logic             state_chg,
    output logic             retry_req
);

    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYCLES - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(TIMEOUT_CYCLES - 1);

    rpa_state_e state_nx;
    logic       wait_expired;

    assign wait_expired = (dwell == WAIT_LAST);

    // Purpose: next-state and retry decision with link loss taking priority.
    always_comb begin
        state_nx  = state;
        retry_req = 1'b0;
        if (!link_ok) begin
            state_nx = ST_WAIT_COND;
        end else if (restart_evt) begin
            state_nx = ST_WAIT_COND;
        end else begin
            case (state)
                ST_WAIT_COND: state_nx = ST_START;
                ST_START: begin
                    if (dwell == PULSE_LAST) begin
                        state_nx = ST_WAIT_DRD;
                    end
                end
                ST_WAIT_DRD: begin
                    if (dlyrst_done) begin
                        state_nx = ST_WAIT_SYNC;
                    end else if (wait_expired) begin
                        state_nx  = ST_WAIT_COND;
                        retry_req = 1'b1;
                    end
                end
                ST_WAIT_SYNC: begin
                    if (sync_done) begin
                        if (phalign_done) begin
                            state_nx = ST_LOCKED;
                        end else begin
                            state_nx  = ST_WAIT_COND;
                            retry_req = 1'b1;
                        end
                    end else if (wait_expired) begin
                        state_nx  = ST_WAIT_COND;
                        retry_req = 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (!data_valid) begin
                        state_nx  = ST_WAIT_COND;
                        retry_req = 1'b1;
                    end
                end
                default: state_nx = ST_WAIT_COND;
            endcase
        end
    end

    assign state_chg = (state_nx != state);

    // Purpose: state register, returning to the condition wait on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT_COND;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/rx_phase_align_seq.sv
// Module rx_phase_align_seq
// Top level of the receive phase alignment sequencer for a receiver whose
// elastic buffer is bypassed. It gates the start pulse on idle exit and
// lock, follows the alignment status handshake, judges the phase result,
// and retries on timeout, failure or invalid fabric data.
// Assumes all status inputs are already synchronous to clk and that
// PULSE_CYCLES (1..4) times the clock period stays below 50 ns.
module rx_phase_align_seq
    import rpa_pkg::*;
#(
    parameter int PULSE_CYCLES   = 3,
    parameter int TIMEOUT_CYCLES = 1024,
    parameter int RETRY_W        = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_evt,
    input  logic               elec_idle,
    input  logic               cdr_lock,
    input  logic               dlyrst_done,
    input  logic               sync_done,
    input  logic               phalign_done,
    input  logic               data_valid,
    output logic               dlyrst_pulse,
    output logic               aligned,
    output logic [RETRY_W-1:0] retry_count
);

    localparam int MAX_WINDOW = (TIMEOUT_CYCLES > PULSE_CYCLES) ? TIMEOUT_CYCLES : PULSE_CYCLES;
    localparam int CNT_W      = $clog2(MAX_WINDOW + 1);

    rpa_state_e       state;
    logic             state_chg;
    logic             retry_req;
    logic             link_ok;
    logic [CNT_W-1:0] dwell;

    assign link_ok = cdr_lock && !elec_idle;

    rpa_dwell_timer #(
        .CNT_W (CNT_W)
    ) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_chg),
        .dwell (dwell)
    );

    rpa_fsm #(
        .PULSE_CYCLES   (PULSE_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
        .CNT_W          (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_ok      (link_ok),
        .restart_evt  (restart_evt),
        .dlyrst_done  (dlyrst_done),
        .sync_done    (sync_done),
        .phalign_done (phalign_done),
        .data_valid   (data_valid),
        .dwell        (dwell),
        .state        (state),
        .state_chg    (state_chg),
        .retry_req    (retry_req)
    );

    rpa_sat_counter #(
        .W (RETRY_W)
    ) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (retry_req),
        .count (retry_count)
    );

    // Purpose: start pulse is cut off at once when the link drops.
    assign dlyrst_pulse = (state == ST_START) && link_ok;

    // Purpose: aligned requires completion, a good result and valid data.
    assign aligned = (state == ST_LOCKED) && link_ok && sync_done && phalign_done && data_valid;

endmodule

// File: rtl/rpa_checker.sv
// Module rpa_checker
// Property checks on the sequencer's ports, attached by bind below.
// Assumes the synchronous active-low reset of the top module.
module rpa_checker #(
    parameter int PULSE_CYCLES = 3,
    parameter int RETRY_W      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               elec_idle,
    input logic               cdr_lock,
    input logic               sync_done,
    input logic               phalign_done,
    input logic               data_valid,
    input logic               dlyrst_pulse,
    input logic               aligned,
    input logic [RETRY_W-1:0] retry_count
);

    logic [3:0] pulse_run;

    // Purpose: length of the current run of start-pulse cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_run <= '0;
        end else if (dlyrst_pulse) begin
            pulse_run <= (pulse_run == 4'hF) ? pulse_run : pulse_run + 4'd1;
        end else begin
            pulse_run <= '0;
        end
    end

    AST_PULSE_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dlyrst_pulse) |-> $past(cdr_lock && !elec_idle)); // R2

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pulse_run) <= PULSE_CYCLES); // R3

    AST_ALIGNED_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |-> (sync_done && phalign_done && data_valid)); // R6

    AST_LINK_LOSS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cdr_lock || elec_idle) |-> (!aligned && !dlyrst_pulse)); // R8

    AST_RETRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_count != $past(retry_count)) |-> (retry_count == $past(retry_count) + 1'b1)); // R11

    AST_RETRY_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (&$past(retry_count)) |-> (&retry_count)); // R11

    AST_NO_SELF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |=> !dlyrst_pulse); // R12

endmodule

bind rx_phase_align_seq rpa_checker #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .RETRY_W      (RETRY_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .elec_idle    (elec_idle),
    .cdr_lock     (cdr_lock),
    .sync_done    (sync_done),
    .phalign_done (phalign_done),
    .data_valid   (data_valid),
    .dlyrst_pulse (dlyrst_pulse),
    .aligned      (aligned),
    .retry_count  (retry_count)
);

// File: tb/rx_phase_align_seq_tb.sv
// Bench for rx_phase_align_seq: directed sequences and timeout sweeps
// with expected gaps and counts computed from the parameters.
module rx_phase_align_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PULSE_N    = 3;
    localparam int TIMEOUT_N  = 8;
    localparam int RETRY_W    = 3;
    localparam int RETRY_MAX  = (1 << RETRY_W) - 1;

    logic clk          = 1'b0;
    logic rst_n        = 1'b0;
    logic restart_evt  = 1'b0;
    logic elec_idle    = 1'b1;
    logic cdr_lock     = 1'b0;
    logic dlyrst_done  = 1'b0;
    logic sync_done    = 1'b0;
    logic phalign_done = 1'b0;
    logic data_valid   = 1'b0;
    logic               dlyrst_pulse;
    logic               aligned;
    logic [RETRY_W-1:0] retry_count;

    int n_chk   = 0;
    int n_bad   = 0;
    int exp_cnt = 0;
    bit done    = 1'b0;

    rx_phase_align_seq #(
        .PULSE_CYCLES   (PULSE_N),
        .TIMEOUT_CYCLES (TIMEOUT_N),
        .RETRY_W        (RETRY_W)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_evt  (restart_evt),
        .elec_idle    (elec_idle),
        .cdr_lock     (cdr_lock),
        .dlyrst_done  (dlyrst_done),
        .sync_done    (sync_done),
        .phalign_done (phalign_done),
        .data_valid   (data_valid),
        .dlyrst_pulse (dlyrst_pulse),
        .aligned      (aligned),
        .retry_count  (retry_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic clear_status();
        dlyrst_done  = 1'b0;
        sync_done    = 1'b0;
        phalign_done = 1'b0;
    endtask

    // From a pulse-high sample, step until the pulse is low; returns its length.
    task automatic pulse_len(output int len);
        len = 0;
        while (dlyrst_pulse && len < 20) begin
            len++;
            step();
        end
    endtask

    // Count low samples until the next pulse; notes any aligned on the way.
    task automatic gap_to_pulse(output int g, output bit saw_al);
        g      = 0;
        saw_al = 1'b0;
        while (!dlyrst_pulse && g < 100) begin
            if (aligned) saw_al = 1'b1;
            g++;
            step();
        end
    endtask

    // From a pulse-high sample, run a successful alignment into completion.
    task automatic align_ok();
        int len;
        pulse_len(len);
        check(len == PULSE_N, "R3 pulse length", len, PULSE_N);
        dlyrst_done = 1'b1;
        step();
        sync_done    = 1'b1;
        phalign_done = 1'b1;
        data_valid   = 1'b1;
        #1;
        check(aligned == 1'b0, "R4 aligned before completion edge", int'(aligned), 0);
        step();
        check(aligned == 1'b1, "R4 aligned after completion", int'(aligned), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        int  len;
        int  g;
        bit  sa;

        // R1: reset state
        repeat (3) step();
        check(dlyrst_pulse == 1'b0, "R1 pulse in reset", int'(dlyrst_pulse), 0);
        check(aligned == 1'b0, "R1 aligned in reset", int'(aligned), 0);
        check(retry_count == 0, "R1 count in reset", int'(retry_count), 0);

        // R2: no pulse while either start condition is missing
        rst_n = 1'b1;
        for (int c = 0; c < 3; c++) begin
            elec_idle = (c != 1);
            cdr_lock  = (c == 2);
            for (int k = 0; k < 4; k++) begin
                step();
                check(dlyrst_pulse == 1'b0, "R2 gated start", int'(dlyrst_pulse), 0);
            end
        end
        elec_idle = 1'b0;
        cdr_lock  = 1'b1;
        #1;
        check(dlyrst_pulse == 1'b0, "R2 not same cycle", int'(dlyrst_pulse), 0);
        step();
        check(dlyrst_pulse == 1'b1, "R2 pulse next cycle", int'(dlyrst_pulse), 1);

        // R3, R4: successful alignment; R12: stays complete
        align_ok();
        for (int k = 0; k < 20; k++) begin
            step();
            check(aligned == 1'b1 && dlyrst_pulse == 1'b0, "R12 hold complete",
                  int'({aligned, dlyrst_pulse}), 2);
        end

        // R6: aligned qualified by sync-done and phase result, no restart
        for (int v = 0; v < 4; v++) begin
            sync_done    = v[1];
            phalign_done = v[0];
            #1;
            check(aligned == (v == 3), "R6 aligned qualifier", int'(aligned), int'(v == 3));
            step();
            check(dlyrst_pulse == 1'b0, "R6 no restart", int'(dlyrst_pulse), 0);
        end
        sync_done    = 1'b1;
        phalign_done = 1'b1;
        #1;

        // R7: invalid fabric data repeats the alignment
        data_valid = 1'b0;
        #1;
        check(aligned == 1'b0, "R7 aligned drops", int'(aligned), 0);
        step();
        exp_cnt++;
        clear_status();
        check(retry_count == exp_cnt, "R7 retry counted", int'(retry_count), exp_cnt);
        check(dlyrst_pulse == 1'b0, "R7 waiting cycle", int'(dlyrst_pulse), 0);
        step();
        check(dlyrst_pulse == 1'b1, "R7 new pulse", int'(dlyrst_pulse), 1);

        // R9: restart request from the completed state
        align_ok();
        restart_evt = 1'b1;
        step();
        restart_evt = 1'b0;
        clear_status();
        check(aligned == 1'b0, "R9 aligned cleared", int'(aligned), 0);
        check(retry_count == exp_cnt, "R9 count unchanged", int'(retry_count), exp_cnt);
        step();
        check(dlyrst_pulse == 1'b1, "R9 new pulse", int'(dlyrst_pulse), 1);

        // R5: phase result low at sync-done
        pulse_len(len);
        dlyrst_done  = 1'b1;
        sync_done    = 1'b1;
        phalign_done = 1'b0;
        gap_to_pulse(g, sa);
        exp_cnt++;
        check(g == 3, "R5 gap to retry pulse", g, 3);
        check(sa == 1'b0, "R5 never aligned", int'(sa), 0);
        check(retry_count == exp_cnt, "R5 retry counted", int'(retry_count), exp_cnt);
        clear_status();

        // R10, R11: timeout sweep over both waits up to saturation
        for (int i = 0; i < 10; i++) begin
            pulse_len(len);
            dlyrst_done = (i % 2 == 1);
            gap_to_pulse(g, sa);
            exp_cnt = (exp_cnt < RETRY_MAX) ? exp_cnt + 1 : RETRY_MAX;
            check(g == TIMEOUT_N + 1 + (i % 2), "R10 timeout gap", g, TIMEOUT_N + 1 + (i % 2));
            check(retry_count == exp_cnt, "R11 saturating count", int'(retry_count), exp_cnt);
            dlyrst_done = 1'b0;
        end

        // R1: reset again with the link up; R2 first edge after release
        rst_n = 1'b0;
        step();
        step();
        check(dlyrst_pulse == 1'b0 && retry_count == 0, "R1 reset clears",
              int'(retry_count), 0);
        exp_cnt = 0;
        rst_n = 1'b1;
        step();
        check(dlyrst_pulse == 1'b1, "R2 pulse after release", int'(dlyrst_pulse), 1);

        // R10 with R8: lock lost in the cycle the wait expires
        pulse_len(len);
        repeat (TIMEOUT_N - 1) step();
        cdr_lock = 1'b0;
        #1;
        check(dlyrst_pulse == 1'b0 && aligned == 1'b0, "R8 quiet on loss",
              int'({dlyrst_pulse, aligned}), 0);
        step();
        check(retry_count == exp_cnt, "R10 link loss wins over timeout", int'(retry_count), exp_cnt);
        for (int k = 0; k < 3; k++) begin
            step();
            check(dlyrst_pulse == 1'b0, "R8 no pulse without lock", int'(dlyrst_pulse), 0);
        end
        cdr_lock = 1'b1;
        step();
        check(dlyrst_pulse == 1'b1, "R8 pulse after lock returns", int'(dlyrst_pulse), 1);

        // R9: restart and invalid data in the same cycle
        align_ok();
        restart_evt = 1'b1;
        data_valid  = 1'b0;
        step();
        restart_evt = 1'b0;
        clear_status();
        check(retry_count == exp_cnt, "R9 restart wins over retry", int'(retry_count), exp_cnt);
        step();
        check(dlyrst_pulse == 1'b1, "R9 pulse after restart", int'(dlyrst_pulse), 1);

        // R8: electrical idle cuts a pulse; the next one is full length
        elec_idle = 1'b1;
        #1;
        check(dlyrst_pulse == 1'b0, "R8 pulse cut by idle", int'(dlyrst_pulse), 0);
        step();
        step();
        check(dlyrst_pulse == 1'b0 && retry_count == exp_cnt, "R8 idle holds off",
              int'(retry_count), exp_cnt);
        elec_idle = 1'b0;
        step();
        check(dlyrst_pulse == 1'b1, "R8 restart after idle", int'(dlyrst_pulse), 1);
        align_ok();

        done = 1'b1;
        report();
        $finish;
    end

endmodule